// File: doc/BRIEF.md
# Internal Data Space Access Router

This block sits between an 8-bit core's operand logic and the 256-byte internal data space. Each cycle it can accept one access. The access consists of an 8-bit address, an access kind and an operation. The kinds are direct, indirect through a pointer register, stack, working register and single bit. The block works out which storage the access reaches: the on-chip RAM array, the status word that it holds itself, or an external special-register bus. It then carries out the read or write.

The working registers are eight bytes in one of four banks at the bottom of RAM. Two bits of the status word choose the bank, so a status-word write moves every later register access. Bit accesses are folded into the byte space in one of two ways. Low bit numbers map to a 16-byte window of RAM. High bit numbers map to the special registers whose addresses are multiples of eight. A bit change is done as a one-cycle read-modify-write of the byte that holds the bit.

Read data is registered and comes out one cycle after the request. The RAM size is a parameter. The full size is 256 bytes. The reduced size is 128 bytes, in which indirect and stack accesses to the upper half are dropped.

Top module: `dmem_router`

## Requirements
- R1: A direct access (kind 0) to addresses 0x00–0x7F reaches RAM. A direct access to 0x80–0xFF other than the status word drives the special-register bus: `sfr_re` for a read, `sfr_we` for a write, with `sfr_addr` equal to the address.
- R2: Indirect (kind 1) and stack (kind 2) accesses to 0x80–0xFF reach upper RAM and never assert `sfr_re` or `sfr_we`. A stack access uses `acc_addr` as the byte address.
- R3: A register access (kind 3) with register number n = `acc_addr[2:0]` reaches RAM byte bank*8 + n. The bank is status-word bits 4:3.
- R4: An indirect access takes its byte address from R0 or R1 of the active bank, chosen by `acc_addr[0]`.
- R5: A bit access (kind 4) to bit numbers 0x00–0x7F reaches RAM byte 0x20 + (bit >> 3), at bit position bit & 7.
- R6: A bit access to bit numbers 0x80–0xFF reaches special byte bit & 0xF8, at bit position bit & 7. A bit read asserts `sfr_re`. A bit change asserts `sfr_re` and `sfr_we` in the same cycle, with the modified byte on `sfr_wdata`.
- R7: The status word is held internally at special address 0xD0 and is output on `stat_word`. Accesses to it never use the bus. A write to it by byte, or to bit 0xD3 or 0xD4, changes the bank for the next access.
- R8: The operation codes are 0 read, 1 write, 2 set and 3 clear. A bit write stores `acc_wdata[0]`. A bit change alters only the addressed bit.
- R9: A read (op 0) gives `rd_valid` and `rd_data` in the next cycle, and no other operation gives `rd_valid`. A bit read returns the bit in `rd_data[0]` with zeros above it. A read in the cycle after a write to the same location returns the new value.
- R10: With `RAM_BYTES` = 128, indirect and stack accesses to 0x80–0xFF read 0x00 and leave storage unchanged.
- R11: Reset clears RAM, the status word and `rd_valid`.
- R12: Set and clear on a byte kind write nothing and assert no bus strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request this cycle |
| acc_kind | input | 3 | 0 direct, 1 indirect, 2 stack, 3 register, 4 bit |
| acc_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| acc_addr | input | 8 | Byte address, register number, pointer select or bit number |
| acc_wdata | input | 8 | Write byte; bit 0 is the bit value for bit writes |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Registered read result |
| stat_word | output | 8 | Status word contents |
| sfr_addr | output | 8 | Special-register bus address |
| sfr_wdata | output | 8 | Special-register bus write byte |
| sfr_we | output | 1 | Special-register bus write strobe |
| sfr_re | output | 1 | Special-register bus read strobe |
| sfr_rdata | input | 8 | Special-register bus read byte, valid in the same cycle |

## Verification
Random mixes of all five kinds and four operations run against a reference model. The model holds its own RAM, status word and special-register image. Indirect and stack traffic above 0x7F is told apart from direct traffic by bus strobes and read-back values. Status-word writes are forced in at intervals so that register and pointer accesses are tried in every bank. Directed sequences cover the cases that random traffic seldom reaches: bank changes through bits 0xD3 and 0xD4, bit changes on special registers, byte set and clear, and the dropped upper half of a second instance built with 128 bytes. A final sweep reads the whole RAM by stack access and checks every special register against the model.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
   typedef enum logic [2:0] {
      K_DIR = 3'd0,
      K_IND = 3'd1,
      K_STK = 3'd2,
      K_REG = 3'd3,
      K_BIT = 3'd4
   } acc_kind_e;

   typedef enum logic [1:0] {
      OP_RD  = 2'd0,
      OP_WR  = 2'd1,
      OP_SET = 2'd2,
      OP_CLR = 2'd3
   } acc_op_e;

   typedef enum logic [1:0] {
      T_NONE = 2'd0,
      T_RAM  = 2'd1,
      T_STAT = 2'd2,
      T_SFR  = 2'd3
   } tgt_e;
endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH),
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);
   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("dmem_ram: DEPTH must be a power of two matching AW");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/dmem_resolve.sv
module dmem_resolve
   import dmem_pkg::*;
#(
   parameter int         RAM_BYTES = 256,
   parameter logic [7:0] STAT_ADDR = 8'hD0,
   parameter logic [7:0] BIT_BASE  = 8'h20
) (
   input  logic       rst_n,
   input  logic       acc_en,
   input  acc_kind_e  kind,
   input  logic [7:0] addr,
   input  logic [1:0] bank,
   input  logic [7:0] ptr_data,
   output logic [7:0] ptr_addr,
   output logic [7:0] byte_addr,
   output logic [2:0] bit_pos,
   output logic       is_bit,
   output tgt_e       tgt
);
   logic upper_ok;

   generate
      if (RAM_BYTES == 256) begin : g_full
         assign upper_ok = 1'b1;
      end else begin : g_half
         assign upper_ok = 1'b0;
      end
   endgenerate

   // pointer register (R0/R1) of the active bank
   assign ptr_addr = {3'b000, bank, 2'b00, addr[0]};

   always_comb begin
      byte_addr = addr;
      bit_pos   = 3'd0;
      is_bit    = 1'b0;
      tgt       = T_NONE;
      unique case (kind)
         K_DIR: begin
            byte_addr = addr;
            if (!addr[7])               tgt = T_RAM;
            else if (addr == STAT_ADDR) tgt = T_STAT;
            else                        tgt = T_SFR;
         end
         K_IND: begin
            byte_addr = ptr_data;
            tgt       = (!ptr_data[7] || upper_ok) ? T_RAM : T_NONE;
         end
         K_STK: begin
            byte_addr = addr;
            tgt       = (!addr[7] || upper_ok) ? T_RAM : T_NONE;
         end
         K_REG: begin
            byte_addr = {3'b000, bank, addr[2:0]};
            tgt       = T_RAM;
         end
         K_BIT: begin
            is_bit  = 1'b1;
            bit_pos = addr[2:0];
            if (!addr[7]) begin
               byte_addr = BIT_BASE + {4'b0000, addr[6:3]};
               tgt       = T_RAM;
            end else begin
               byte_addr = {addr[7:3], 3'b000};
               tgt       = (byte_addr == STAT_ADDR) ? T_STAT : T_SFR;
            end
         end
         default: tgt = T_NONE;
      endcase
   end

   always_comb begin
      if (rst_n && acc_en && kind == K_REG) begin
         assert_reg_bank_R3: assert (byte_addr < 8'h20 && byte_addr[2:0] == addr[2:0]);
      end
      if (rst_n && acc_en && kind == K_BIT && !addr[7]) begin
         assert_bit_window_R5: assert (byte_addr >= BIT_BASE && byte_addr < BIT_BASE + 8'h10 && tgt == T_RAM);
      end
      if (rst_n && acc_en && kind == K_BIT && addr[7]) begin
         assert_bit_sfr_align_R6: assert (byte_addr[2:0] == 3'b000 && tgt != T_RAM);
      end
   end
endmodule

// File: rtl/dmem_bitop.sv
module dmem_bitop
   import dmem_pkg::*;
#(
   parameter int DW = 8,
   parameter int PW = $clog2(DW)
) (
   input  logic          rst_n,
   input  logic          active,
   input  logic [DW-1:0] old_byte,
   input  logic [PW-1:0] pos,
   input  acc_op_e       op,
   input  logic          wbit,
   output logic [DW-1:0] new_byte,
   output logic          bit_val
);
   logic [DW-1:0] sel;

   generate
      for (genvar g = 0; g < DW; g++) begin : g_lane
         assign sel[g] = (pos == PW'(g));
         always_comb begin
            new_byte[g] = old_byte[g];
            if (sel[g]) begin
               unique case (op)
                  OP_WR:   new_byte[g] = wbit;
                  OP_SET:  new_byte[g] = 1'b1;
                  OP_CLR:  new_byte[g] = 1'b0;
                  default: new_byte[g] = old_byte[g];
               endcase
            end
         end
      end
   endgenerate

   assign bit_val = |(old_byte & sel);

   always_comb begin
      if (rst_n && active) begin
         assert_single_bit_R8: assert ($countones(old_byte ^ new_byte) <= 1);
      end
   end
endmodule

// File: rtl/dmem_router.sv
module dmem_router
   import dmem_pkg::*;
#(
   parameter int         RAM_BYTES = 256,
   parameter logic [7:0] STAT_ADDR = 8'hD0,
   parameter int         BANK_LSB  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       acc_en,
   input  logic [2:0] acc_kind,
   input  logic [1:0] acc_op,
   input  logic [7:0] acc_addr,
   input  logic [7:0] acc_wdata,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic [7:0] stat_word,
   output logic [7:0] sfr_addr,
   output logic [7:0] sfr_wdata,
   output logic       sfr_we,
   output logic       sfr_re,
   input  logic [7:0] sfr_rdata
);
   localparam int RAM_AW = $clog2(RAM_BYTES);

   generate
      if (RAM_BYTES != 128 && RAM_BYTES != 256) begin : g_bad_size
         $error("dmem_router: RAM_BYTES must be 128 or 256");
      end
      if (BANK_LSB < 0 || BANK_LSB > 6) begin : g_bad_bank
         $error("dmem_router: BANK_LSB out of range");
      end
      if (STAT_ADDR[7] != 1'b1) begin : g_bad_stat
         $error("dmem_router: STAT_ADDR must lie in the upper half");
      end
   endgenerate

   acc_kind_e kind;
   acc_op_e   op;
   assign kind = acc_kind_e'(acc_kind);
   assign op   = acc_op_e'(acc_op);

   logic [7:0] psw_q;
   logic [1:0] bank;
   assign bank      = psw_q[BANK_LSB+1:BANK_LSB];
   assign stat_word = psw_q;

   logic [7:0] ptr_addr, ptr_data, byte_addr, ram_rd;
   logic [2:0] bit_pos;
   logic       is_bit;
   tgt_e       tgt;

   dmem_resolve #(
      .RAM_BYTES(RAM_BYTES),
      .STAT_ADDR(STAT_ADDR),
      .BIT_BASE (8'h20)
   ) u_resolve (
      .rst_n    (rst_n),
      .acc_en   (acc_en),
      .kind     (kind),
      .addr     (acc_addr),
      .bank     (bank),
      .ptr_data (ptr_data),
      .ptr_addr (ptr_addr),
      .byte_addr(byte_addr),
      .bit_pos  (bit_pos),
      .is_bit   (is_bit),
      .tgt      (tgt)
   );

   logic [7:0] old_byte, bit_new, new_byte;
   logic       bit_val, write_req, ram_we;

   always_comb begin
      unique case (tgt)
         T_RAM:   old_byte = ram_rd;
         T_STAT:  old_byte = psw_q;
         T_SFR:   old_byte = sfr_rdata;
         default: old_byte = 8'h00;
      endcase
   end

   dmem_bitop #(.DW(8)) u_bitop (
      .rst_n   (rst_n),
      .active  (acc_en && is_bit),
      .old_byte(old_byte),
      .pos     (bit_pos),
      .op      (op),
      .wbit    (acc_wdata[0]),
      .new_byte(bit_new),
      .bit_val (bit_val)
   );

   assign write_req = acc_en && (is_bit ? (op != OP_RD) : (op == OP_WR));
   assign new_byte  = is_bit ? bit_new : acc_wdata;
   assign ram_we    = write_req && (tgt == T_RAM);

   dmem_ram #(.DEPTH(RAM_BYTES), .AW(RAM_AW), .DW(8)) u_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ram_we),
      .waddr  (byte_addr[RAM_AW-1:0]),
      .wdata  (new_byte),
      .raddr_a(byte_addr[RAM_AW-1:0]),
      .rdata_a(ram_rd),
      .raddr_b(ptr_addr[RAM_AW-1:0]),
      .rdata_b(ptr_data)
   );

   // external special-register bus
   assign sfr_re    = acc_en && (tgt == T_SFR) && (is_bit || op == OP_RD);
   assign sfr_we    = write_req && (tgt == T_SFR);
   assign sfr_addr  = (tgt == T_SFR) ? byte_addr : 8'h00;
   assign sfr_wdata = (tgt == T_SFR) ? new_byte : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psw_q <= 8'h00;
      end else if (write_req && tgt == T_STAT) begin
         psw_q <= new_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 8'h00;
      end else begin
         rd_valid <= acc_en && (op == OP_RD);
         if (acc_en && op == OP_RD) rd_data <= is_bit ? {7'b0000000, bit_val} : old_byte;
      end
   end

   assert_dir_sfr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_kind == 3'd0 && acc_addr[7] && acc_addr != STAT_ADDR && acc_op == 2'd0)
      |-> (sfr_re && !sfr_we && sfr_addr == acc_addr));

   assert_ind_no_sfr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && (acc_kind == 3'd1 || acc_kind == 3'd2)) |-> (!sfr_re && !sfr_we));

   assert_stat_no_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_kind == 3'd0 && acc_addr == STAT_ADDR) |-> (!sfr_re && !sfr_we));

   assert_psw_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en && tgt == T_STAT) |=> $stable(psw_q));

   assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_op == 2'd0) |=> rd_valid);

   assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en && acc_op == 2'd0) |=> !rd_valid);

   assert_byte_setclr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_kind != 3'd4 && acc_op[1]) |-> (!sfr_we && !sfr_re));

   generate
      if (RAM_BYTES < 256) begin : g_small_chk
         assert_upper_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && (acc_kind == 3'd1 || acc_kind == 3'd2) && byte_addr[7]) |-> !ram_we);
      end
   endgenerate
endmodule

// File: tb/sim_dmem_router.sv
`timescale 1ns/1ps
module sim_dmem_router;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0;
   logic [2:0] acc_kind = '0;
   logic [1:0] acc_op = '0;
   logic [7:0] acc_addr = '0, acc_wdata = '0;
   logic       rd_valid, sfr_we, sfr_re;
   logic [7:0] rd_data, stat_word, sfr_addr, sfr_wdata, sfr_rdata;

   logic       s_en = 1'b0;
   logic [2:0] s_kind = '0;
   logic [1:0] s_op = '0;
   logic [7:0] s_addr = '0, s_wdata = '0;
   logic       s_rv, s_we, s_re;
   logic [7:0] s_rd, s_stat, s_saddr, s_swdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [7:0] per_mem [256];
   logic [7:0] exp_sfr [256];
   logic [7:0] m_ram   [256];
   logic [7:0] m_psw;

   always #2.5 clk = ~clk;

   assign sfr_rdata = per_mem[sfr_addr];
   always @(posedge clk) if (sfr_we) per_mem[sfr_addr] <= sfr_wdata;

   dmem_router u0 (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_kind(acc_kind), .acc_op(acc_op),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .stat_word(stat_word), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
      .sfr_re(sfr_re), .sfr_rdata(sfr_rdata)
   );

   dmem_router #(.RAM_BYTES(128)) u1 (
      .clk(clk), .rst_n(rst_n), .acc_en(s_en), .acc_kind(s_kind), .acc_op(s_op),
      .acc_addr(s_addr), .acc_wdata(s_wdata), .rd_valid(s_rv), .rd_data(s_rd),
      .stat_word(s_stat), .sfr_addr(s_saddr), .sfr_wdata(s_swdata), .sfr_we(s_we),
      .sfr_re(s_re), .sfr_rdata(8'h00)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // reference model: returns expected outputs from the pre-access state, then updates it
   task automatic model(input logic [2:0] k, input logic [7:0] a, input logic [1:0] o,
                        input logic [7:0] d, output logic [7:0] erd, output bit ev,
                        output bit ebus, output logic [7:0] eba, output bit ewe);
      logic [1:0] bank;
      int         t;
      bit         isb, wr;
      logic [2:0] pos;
      logic [7:0] old, nw;
      bank = m_psw[4:3];
      isb  = 0;
      pos  = 3'd0;
      t    = 0;
      eba  = a;
      case (k)
         3'd0: begin eba = a; t = (a < 8'h80) ? 1 : ((a == 8'hD0) ? 2 : 3); end
         3'd1: begin eba = m_ram[{3'b000, bank, 2'b00, a[0]}]; t = 1; end
         3'd2: begin eba = a; t = 1; end
         3'd3: begin eba = {3'b000, bank, a[2:0]}; t = 1; end
         3'd4: begin
            isb = 1; pos = a[2:0];
            if (a < 8'h80) begin eba = 8'h20 + (a >> 3); t = 1; end
            else begin eba = a & 8'hF8; t = (eba == 8'hD0) ? 2 : 3; end
         end
         default: t = 0;
      endcase
      old = (t == 1) ? m_ram[eba] : (t == 2) ? m_psw : (t == 3) ? exp_sfr[eba] : 8'h00;
      wr  = isb ? (o != 2'd0) : (o == 2'd1);
      nw  = old;
      if (isb) nw[pos] = (o == 2'd1) ? d[0] : (o == 2'd2);
      else     nw = d;
      erd  = isb ? {7'b0, old[pos]} : old;
      ev   = (o == 2'd0);
      ebus = (t == 3) && (isb || o == 2'd0 || o == 2'd1);
      ewe  = wr && (t == 3);
      if (wr) begin
         if (t == 1) m_ram[eba] = nw;
         else if (t == 2) m_psw = nw;
         else if (t == 3) exp_sfr[eba] = nw;
      end
   endtask

   task automatic acc(input logic [2:0] k, input logic [7:0] a, input logic [1:0] o,
                      input logic [7:0] d, input string tag);
      logic [7:0] erd, eba;
      bit ev, ebus, ewe;
      model(k, a, o, d, erd, ev, ebus, eba, ewe);
      acc_en = 1'b1; acc_kind = k; acc_addr = a; acc_op = o; acc_wdata = d;
      #1;
      check((sfr_re | sfr_we) == ebus, tag, "bus strobe", {7'b0, sfr_re | sfr_we}, {7'b0, ebus});
      check(sfr_we == ewe, tag, "bus write", {7'b0, sfr_we}, {7'b0, ewe});
      if (ebus) check(sfr_addr == eba, tag, "bus addr", sfr_addr, eba);
      @(negedge clk);
      acc_en = 1'b0;
      check(rd_valid == ev, tag, "rd_valid", {7'b0, rd_valid}, {7'b0, ev});
      if (ev) check(rd_data == erd, tag, "rd_data", rd_data, erd);
      check(stat_word == m_psw, tag, "stat_word", stat_word, m_psw);
   endtask

   task automatic acc_small(input logic [2:0] k, input logic [7:0] a, input logic [1:0] o,
                            input logic [7:0] d, input logic [7:0] exp_rd, input string tag);
      s_en = 1'b1; s_kind = k; s_addr = a; s_op = o; s_wdata = d;
      #1;
      check(!s_re && !s_we, tag, "small bus strobe", {6'b0, s_re, s_we}, 8'h00);
      @(negedge clk);
      s_en = 1'b0;
      if (o == 2'd0) check(s_rv && s_rd == exp_rd, tag, "small rd_data", s_rd, exp_rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'd20240611);
      for (int i = 0; i < 256; i++) begin
         per_mem[i] = 8'(i) ^ 8'h5A;
         exp_sfr[i] = 8'(i) ^ 8'h5A;
         m_ram[i]   = 8'h00;
      end
      m_psw = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      check(rd_valid == 1'b0, "R11", "rd_valid after reset", {7'b0, rd_valid}, 8'h00);
      check(stat_word == 8'h00, "R11", "stat_word after reset", stat_word, 8'h00);
      acc(3'd2, 8'h05, 2'd0, 8'h00, "R11");
      acc(3'd2, 8'hC3, 2'd0, 8'h00, "R11");

      // R1 direct low RAM and upper special registers
      acc(3'd0, 8'h40, 2'd1, 8'h3C, "R1");
      acc(3'd0, 8'h40, 2'd0, 8'h00, "R1");
      acc(3'd0, 8'h90, 2'd0, 8'h00, "R1");
      acc(3'd0, 8'hA5, 2'd1, 8'hE1, "R1");
      // R2 stack/indirect in the upper half do not use the bus
      acc(3'd2, 8'hA5, 2'd1, 8'h77, "R2");
      acc(3'd2, 8'hA5, 2'd0, 8'h00, "R2");
      // R7 bank via byte write to status word, R3 register mapping
      acc(3'd0, 8'hD0, 2'd1, 8'h10, "R7");
      acc(3'd3, 8'h05, 2'd1, 8'h9B, "R3");
      acc(3'd2, 8'h15, 2'd0, 8'h00, "R3");
      // R4 pointer from R1 of bank 2
      acc(3'd3, 8'h01, 2'd1, 8'hB0, "R4");
      acc(3'd1, 8'h01, 2'd1, 8'h6E, "R4");
      acc(3'd2, 8'hB0, 2'd0, 8'h00, "R4");
      // R7 bank via bit 0xD3 then 0xD4 clear
      acc(3'd4, 8'hD3, 2'd2, 8'h00, "R7");
      acc(3'd3, 8'h00, 2'd1, 8'h44, "R7");
      acc(3'd2, 8'h18, 2'd0, 8'h00, "R7");
      acc(3'd4, 8'hD4, 2'd3, 8'h00, "R7");
      acc(3'd3, 8'h00, 2'd0, 8'h00, "R7");
      // R5 bit window in RAM, R8 operations
      acc(3'd4, 8'h0B, 2'd2, 8'h00, "R5");
      acc(3'd2, 8'h21, 2'd0, 8'h00, "R5");
      acc(3'd4, 8'h7F, 2'd1, 8'h01, "R8");
      acc(3'd4, 8'h7F, 2'd0, 8'h00, "R8");
      acc(3'd4, 8'h0B, 2'd3, 8'h00, "R8");
      acc(3'd2, 8'h21, 2'd0, 8'h00, "R8");
      // R6 bit on special register 0x88
      acc(3'd4, 8'h8A, 2'd2, 8'h00, "R6");
      acc(3'd4, 8'h8A, 2'd0, 8'h00, "R6");
      acc(3'd0, 8'h88, 2'd0, 8'h00, "R6");
      // R12 byte set/clear do nothing
      acc(3'd0, 8'h98, 2'd2, 8'hFF, "R12");
      acc(3'd0, 8'h98, 2'd0, 8'h00, "R12");
      acc(3'd2, 8'h30, 2'd3, 8'hFF, "R12");
      // R9 write then immediate read
      acc(3'd2, 8'h55, 2'd1, 8'hC7, "R9");
      acc(3'd2, 8'h55, 2'd0, 8'h00, "R9");

      // constrained random mix
      for (int i = 0; i < 1500; i++) begin
         if ($urandom_range(9, 0) == 0)
            acc(3'd0, 8'hD0, 2'd1, 8'($urandom_range(255, 0)), "R7");
         else
            acc(3'($urandom_range(4, 0)), 8'($urandom_range(255, 0)),
                2'($urandom_range(3, 0)), 8'($urandom_range(255, 0)), "R9");
      end

      // final sweep
      for (int i = 0; i < 256; i++) acc(3'd2, 8'(i), 2'd0, 8'h00, "R2");
      @(negedge clk);
      for (int i = 0; i < 256; i++)
         if (i != 8'hD0) check(per_mem[i] === exp_sfr[i], "R6", "special image", per_mem[i], exp_sfr[i]);

      // R10 reduced RAM instance
      acc_small(3'd2, 8'h90, 2'd1, 8'h55, 8'h00, "R10");
      acc_small(3'd2, 8'h90, 2'd0, 8'h00, 8'h00, "R10");
      acc_small(3'd2, 8'h10, 2'd1, 8'h66, 8'h00, "R10");
      acc_small(3'd2, 8'h10, 2'd0, 8'h00, 8'h66, "R10");
      acc_small(3'd3, 8'h00, 2'd1, 8'h85, 8'h00, "R10");
      acc_small(3'd1, 8'h00, 2'd1, 8'hAB, 8'h00, "R10");
      acc_small(3'd1, 8'h00, 2'd0, 8'h00, 8'h00, "R10");
      acc_small(3'd2, 8'h05, 2'd0, 8'h00, 8'h00, "R10");

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule